// File: doc/BRIEF.md
# Reorder Buffer with Head-Only Recovery

This block keeps every in-flight instruction in a circular window, from the moment it is issued to the moment it retires. The front end writes one entry per cycle, in program order, at the tail. Each entry holds the architectural destination, the physical register it was given, and the physical register that held the previous value. Execution units later report completion for any entry, in any order. A completion carries an outcome kind, a program counter and a cause code.

Only the oldest entry can act. A clean entry at the head retires and names the old physical register, which can then be freed. A mispredicted branch at the head retires and redirects fetch to the correct target. A load that broke memory ordering is not retired: it redirects fetch to its own address so that it is fetched again. An exception is not retired either: it redirects fetch to a fixed handler address and reports its cause. After any redirect, the block squashes the remaining entries one per cycle, oldest first. Each squash names the newly assigned physical register so that it can be returned to the free pool. Allocation is held off while entries are squashed.

Top module: `reorder_buffer`

## Requirements
- R1: After a synchronous reset the window is empty: `alloc_stall`, `commit_valid`, `flush_valid` and `squash_valid` are 0, and `alloc_tag` is 0.
- R2: An allocation is accepted when `alloc_valid` is 1 and `alloc_stall` is 0. Accepted entries receive tags 0,1,2,… modulo DEPTH, in order. `alloc_stall` is 1 while DEPTH entries are held, and an allocation attempted while it is 1 is dropped.
- R3: Completion may arrive in any order. An entry commits only when it is at the head and has completed with kind 0 (clean) or kind 1 (mispredict). A completed younger entry waits for all older entries.
- R4: At most one entry commits per cycle, in allocation order. A commit reports the entry's `commit_areg`, `commit_new_preg` and the previous mapping on `commit_free_preg`.
- R5: A head entry completed with kind 1 commits and asserts `flush_valid` in the same cycle. It gives `flush_pc` equal to its stored pc and `flush_exception` 0. All younger entries are discarded.
- R6: A head entry completed with kind 2 (ordering violation) does not commit. It asserts `flush_valid` with `flush_pc` equal to its stored pc and `flush_exception` 0, and it is discarded together with all younger entries.
- R7: A head entry completed with kind 3 (exception) does not commit. It asserts `flush_valid` with `flush_pc` equal to HANDLER_PC, `flush_exception` 1 and `flush_cause` equal to its stored cause.
- R8: After a flush, each discarded entry asserts `squash_valid` for one cycle, oldest first, with `squash_preg` equal to its new physical register. `alloc_stall` is 1 in the flush cycle and during squashing. Allocations attempted then are dropped, and tags continue in sequence afterwards.
- R9: A flagged completion (kind 1–3) on an entry that is not at the head causes no flush. Entries squashed after a flush never commit or flush, whatever completions they receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to allocate one entry |
| alloc_areg | input | AREG_W | Architectural destination |
| alloc_old_preg | input | PREG_W | Physical register of the previous value |
| alloc_new_preg | input | PREG_W | Newly assigned physical register |
| alloc_stall | output | 1 | No allocation accepted this cycle |
| alloc_tag | output | log2(DEPTH) | Tag the next accepted entry receives |
| cpl_valid | input | 1 | Completion report valid |
| cpl_tag | input | log2(DEPTH) | Entry that completed |
| cpl_kind | input | 2 | 0 clean, 1 mispredict, 2 ordering violation, 3 exception |
| cpl_pc | input | PC_W | Correct target or refetch address |
| cpl_cause | input | CAUSE_W | Exception cause code |
| commit_valid | output | 1 | Head entry retires this cycle |
| commit_areg | output | AREG_W | Retiring destination |
| commit_new_preg | output | PREG_W | Physical register now architectural |
| commit_free_preg | output | PREG_W | Physical register to release |
| flush_valid | output | 1 | Redirect fetch and discard the window |
| flush_pc | output | PC_W | Fetch redirect address |
| flush_exception | output | 1 | Redirect is to the handler |
| flush_cause | output | CAUSE_W | Cause of the exception |
| squash_valid | output | 1 | One discarded entry reported |
| squash_preg | output | PREG_W | Physical register of the discarded entry |

## Verification
The bound checker watches every cycle. It checks that tags advance by one per accepted allocation and that a full window stalls. It checks that an empty window neither commits nor flushes, that an exception never retires, that a flush lasts one cycle, and that squash cycles are quiet and stalled. Only the directed scenarios can show the values that matter. These are the order of commits after out-of-order completion, the register names reported, each redirect address and cause, the order of squashed registers, and that a stalled or flagged-but-younger input really had no effect.

// File: rtl/rob_pkg.sv
package rob_pkg;

    parameter int AREG_W  = 5;
    parameter int PREG_W  = 7;
    parameter int PC_W    = 32;
    parameter int CAUSE_W = 5;

    typedef enum logic [1:0] {
        KIND_CLEAN   = 2'd0,
        KIND_MISPRED = 2'd1,
        KIND_ORDER   = 2'd2,
        KIND_EXC     = 2'd3
    } kind_e;

    // Register mapping captured at allocation
    typedef struct packed {
        logic [AREG_W-1:0] areg;
        logic [PREG_W-1:0] old_preg;
        logic [PREG_W-1:0] new_preg;
    } map_t;

    // Outcome written by execution
    typedef struct packed {
        logic               done;
        kind_e              kind;
        logic [PC_W-1:0]    pc;
        logic [CAUSE_W-1:0] cause;
    } status_t;

    // Head entries of this kind update architectural state
    function automatic logic kind_retires(kind_e k);
        return (k == KIND_CLEAN) || (k == KIND_MISPRED);
    endfunction

    // Head entries of this kind redirect fetch
    function automatic logic kind_redirects(kind_e k);
        return k != KIND_CLEAN;
    endfunction

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic [IDX_W:0]   count,
    output logic             full,
    output logic             empty
);
    // Extra top bit distinguishes a full window from an empty one
    logic [IDX_W:0] head_q;
    logic [IDX_W:0] tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (push) tail_q <= tail_q + (IDX_W+1)'(1);
            if (pop)  head_q <= head_q + (IDX_W+1)'(1);
        end
    end

    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign count    = tail_q - head_q;
    assign empty    = (head_q == tail_q);
    assign full     = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) &&
                      (head_q[IDX_W] != tail_q[IDX_W]);

endmodule

// File: rtl/rob_entries.sv
module rob_entries
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc_en,
    input  logic [IDX_W-1:0]   alloc_idx,
    input  map_t               alloc_map,
    input  logic               cpl_en,
    input  logic [IDX_W-1:0]   cpl_idx,
    input  kind_e              cpl_kind,
    input  logic [PC_W-1:0]    cpl_pc,
    input  logic [CAUSE_W-1:0] cpl_cause,
    input  logic [IDX_W-1:0]   head_idx,
    output map_t               head_map,
    output status_t            head_stat
);
    map_t    map_q  [DEPTH];
    status_t stat_q [DEPTH];

    // Mapping is written once per allocation
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (alloc_en && alloc_idx == IDX_W'(i))
                map_q[i] <= alloc_map;
        end
    end

    // A fresh allocation clears the outcome; completion fills it in
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                stat_q[i] <= '0;
            end else if (alloc_en && alloc_idx == IDX_W'(i)) begin
                stat_q[i] <= '0;
            end else if (cpl_en && cpl_idx == IDX_W'(i)) begin
                stat_q[i].done  <= 1'b1;
                stat_q[i].kind  <= cpl_kind;
                stat_q[i].pc    <= cpl_pc;
                stat_q[i].cause <= cpl_cause;
            end
        end
    end

    assign head_map  = map_q[head_idx];
    assign head_stat = stat_q[head_idx];

endmodule

// File: rtl/rob_retire.sv
module rob_retire
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_8000,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               empty,
    input  logic [IDX_W:0]     count,
    input  status_t            head_stat,
    output logic               commit,
    output logic               flush,
    output logic [PC_W-1:0]    flush_pc,
    output logic               flush_exc,
    output logic [CAUSE_W-1:0] flush_cause,
    output logic               squash,
    output logic               pop,
    output logic               running
);
    typedef enum logic {ST_RUN, ST_DRAIN} state_e;

    state_e state_q, state_d;
    logic   head_ready;
    logic   last_entry;

    assign running    = (state_q == ST_RUN);
    assign head_ready = running && !empty && head_stat.done;
    assign last_entry = (count == (IDX_W+1)'(1));

    assign commit = head_ready && kind_retires(head_stat.kind);
    assign flush  = head_ready && kind_redirects(head_stat.kind);
    assign squash = (state_q == ST_DRAIN) && !empty;
    assign pop    = commit || squash;

    assign flush_exc   = (head_stat.kind == KIND_EXC);
    assign flush_pc    = flush_exc ? HANDLER_PC : head_stat.pc;
    assign flush_cause = head_stat.cause;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN: begin
                // Drain unless the retiring branch was the only entry
                if (flush && !(commit && last_entry))
                    state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (empty || last_entry)
                    state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_8000,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc_valid,
    input  logic [AREG_W-1:0]  alloc_areg,
    input  logic [PREG_W-1:0]  alloc_old_preg,
    input  logic [PREG_W-1:0]  alloc_new_preg,
    output logic               alloc_stall,
    output logic [IDX_W-1:0]   alloc_tag,
    input  logic               cpl_valid,
    input  logic [IDX_W-1:0]   cpl_tag,
    input  logic [1:0]         cpl_kind,
    input  logic [PC_W-1:0]    cpl_pc,
    input  logic [CAUSE_W-1:0] cpl_cause,
    output logic               commit_valid,
    output logic [AREG_W-1:0]  commit_areg,
    output logic [PREG_W-1:0]  commit_new_preg,
    output logic [PREG_W-1:0]  commit_free_preg,
    output logic               flush_valid,
    output logic [PC_W-1:0]    flush_pc,
    output logic               flush_exception,
    output logic [CAUSE_W-1:0] flush_cause,
    output logic               squash_valid,
    output logic [PREG_W-1:0]  squash_preg
);
    logic             push, pop, full, empty, running;
    logic [IDX_W-1:0] head_idx, tail_idx;
    logic [IDX_W:0]   count;
    map_t             new_map, head_map;
    status_t          head_stat;

    assign alloc_stall = full || !running || flush_valid;
    assign push        = alloc_valid && !alloc_stall;
    assign alloc_tag   = tail_idx;

    assign new_map.areg     = alloc_areg;
    assign new_map.old_preg = alloc_old_preg;
    assign new_map.new_preg = alloc_new_preg;

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .count    (count),
        .full     (full),
        .empty    (empty)
    );

    rob_entries #(.DEPTH(DEPTH)) u_entries (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (push),
        .alloc_idx (tail_idx),
        .alloc_map (new_map),
        .cpl_en    (cpl_valid),
        .cpl_idx   (cpl_tag),
        .cpl_kind  (kind_e'(cpl_kind)),
        .cpl_pc    (cpl_pc),
        .cpl_cause (cpl_cause),
        .head_idx  (head_idx),
        .head_map  (head_map),
        .head_stat (head_stat)
    );

    rob_retire #(.DEPTH(DEPTH), .HANDLER_PC(HANDLER_PC)) u_retire (
        .clk         (clk),
        .rst         (rst),
        .empty       (empty),
        .count       (count),
        .head_stat   (head_stat),
        .commit      (commit_valid),
        .flush       (flush_valid),
        .flush_pc    (flush_pc),
        .flush_exc   (flush_exception),
        .flush_cause (flush_cause),
        .squash      (squash_valid),
        .pop         (pop),
        .running     (running)
    );

    assign commit_areg      = head_map.areg;
    assign commit_new_preg  = head_map.new_preg;
    assign commit_free_preg = head_map.old_preg;
    assign squash_preg      = head_map.new_preg;

endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             alloc_valid,
    input logic             alloc_stall,
    input logic [IDX_W-1:0] alloc_tag,
    input logic             commit_valid,
    input logic             flush_valid,
    input logic             flush_exception,
    input logic             squash_valid
);
    localparam logic [IDX_W:0] FULL_CNT = (IDX_W+1)'(DEPTH);

    // Occupancy reconstructed from port traffic only
    logic [IDX_W:0] occ;
    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else occ <= occ + (IDX_W+1)'(alloc_valid && !alloc_stall)
                        - (IDX_W+1)'(commit_valid || squash_valid);
    end

    AST_TAG_STEP: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !alloc_stall) |=> alloc_tag == IDX_W'($past(alloc_tag) + 1'b1)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (occ == FULL_CNT) |-> alloc_stall); // R2
    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> !commit_valid && !flush_valid && !squash_valid); // R3
    AST_EXC_NO_RETIRE: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && flush_exception) |-> !commit_valid); // R7
    AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        flush_valid |=> !flush_valid); // R5
    AST_SQUASH_QUIET: assert property (@(posedge clk) disable iff (rst)
        squash_valid |-> !commit_valid && !flush_valid && alloc_stall); // R8

endmodule

bind reorder_buffer rob_checker #(.DEPTH(DEPTH)) u_rob_checker (
    .clk             (clk),
    .rst             (rst),
    .alloc_valid     (alloc_valid),
    .alloc_stall     (alloc_stall),
    .alloc_tag       (alloc_tag),
    .commit_valid    (commit_valid),
    .flush_valid     (flush_valid),
    .flush_exception (flush_exception),
    .squash_valid    (squash_valid)
);

// File: tb/reorder_buffer_test.sv
module reorder_buffer_test;
    localparam int DEPTH = 8;
    localparam logic [31:0] HANDLER = 32'h0000_8000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alloc_valid = 1'b0;
    logic [4:0]  alloc_areg = '0;
    logic [6:0]  alloc_old_preg = '0;
    logic [6:0]  alloc_new_preg = '0;
    logic        alloc_stall;
    logic [2:0]  alloc_tag;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_tag = '0;
    logic [1:0]  cpl_kind = '0;
    logic [31:0] cpl_pc = '0;
    logic [4:0]  cpl_cause = '0;
    logic        commit_valid;
    logic [4:0]  commit_areg;
    logic [6:0]  commit_new_preg;
    logic [6:0]  commit_free_preg;
    logic        flush_valid;
    logic [31:0] flush_pc;
    logic        flush_exception;
    logic [4:0]  flush_cause;
    logic        squash_valid;
    logic [6:0]  squash_preg;

    int   n_chk = 0;
    int   n_bad = 0;
    int   exp_tail = 0;
    bit   finished = 0;

    always #5 clk = ~clk;

    reorder_buffer uut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_areg(alloc_areg),
        .alloc_old_preg(alloc_old_preg), .alloc_new_preg(alloc_new_preg),
        .alloc_stall(alloc_stall), .alloc_tag(alloc_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_kind(cpl_kind),
        .cpl_pc(cpl_pc), .cpl_cause(cpl_cause),
        .commit_valid(commit_valid), .commit_areg(commit_areg),
        .commit_new_preg(commit_new_preg), .commit_free_preg(commit_free_preg),
        .flush_valid(flush_valid), .flush_pc(flush_pc),
        .flush_exception(flush_exception), .flush_cause(flush_cause),
        .squash_valid(squash_valid), .squash_preg(squash_preg)
    );

    task automatic expect_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_quiet(string req);
        expect_eq(req, "commit_valid", 32'(commit_valid), 0);
        expect_eq(req, "flush_valid", 32'(flush_valid), 0);
        expect_eq(req, "squash_valid", 32'(squash_valid), 0);
    endtask

    task automatic do_alloc(logic [4:0] a, logic [6:0] o, logic [6:0] n);
        expect_eq("R2", "stall before alloc", 32'(alloc_stall), 0);
        expect_eq("R2", "alloc_tag", 32'(alloc_tag), 32'(exp_tail));
        alloc_valid = 1'b1; alloc_areg = a; alloc_old_preg = o; alloc_new_preg = n;
        @(negedge clk);
        alloc_valid = 1'b0;
        exp_tail = (exp_tail + 1) % DEPTH;
    endtask

    task automatic do_cpl(int tag, logic [1:0] kind, logic [31:0] pc, logic [4:0] cause);
        cpl_valid = 1'b1; cpl_tag = 3'(tag); cpl_kind = kind; cpl_pc = pc; cpl_cause = cause;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic expect_commit(string req, logic [4:0] a, logic [6:0] n, logic [6:0] o);
        expect_eq(req, "commit_valid", 32'(commit_valid), 1);
        expect_eq(req, "commit_areg", 32'(commit_areg), 32'(a));
        expect_eq(req, "commit_new_preg", 32'(commit_new_preg), 32'(n));
        expect_eq(req, "commit_free_preg", 32'(commit_free_preg), 32'(o));
    endtask

    task automatic expect_squash(logic [6:0] p);
        expect_eq("R8", "squash_valid", 32'(squash_valid), 1);
        expect_eq("R8", "squash_preg", 32'(squash_preg), 32'(p));
        expect_eq("R8", "stall during squash", 32'(alloc_stall), 1);
        expect_eq("R9", "no commit while squashing", 32'(commit_valid), 0);
        expect_eq("R9", "no flush while squashing", 32'(flush_valid), 0);
    endtask

    task automatic t_reset;
        expect_quiet("R1");
        expect_eq("R1", "alloc_stall", 32'(alloc_stall), 0);
        expect_eq("R1", "alloc_tag", 32'(alloc_tag), 0);
    endtask

    task automatic t_out_of_order;
        do_alloc(5'd1, 7'd10, 7'd20);
        do_alloc(5'd2, 7'd11, 7'd21);
        do_alloc(5'd3, 7'd12, 7'd22);
        do_cpl(2, 2'd0, 0, 0);
        expect_eq("R3", "young done waits", 32'(commit_valid), 0);
        do_cpl(1, 2'd0, 0, 0);
        expect_eq("R3", "young done waits", 32'(commit_valid), 0);
        do_cpl(0, 2'd0, 0, 0);
        expect_commit("R4", 5'd1, 7'd20, 7'd10);
        @(negedge clk);
        expect_commit("R4", 5'd2, 7'd21, 7'd11);
        @(negedge clk);
        expect_commit("R4", 5'd3, 7'd22, 7'd12);
        @(negedge clk);
        expect_quiet("R3");
    endtask

    task automatic t_fill_wrap;
        int first;
        first = exp_tail;
        for (int i = 0; i < DEPTH; i++) do_alloc(5'(i), 7'(i + 8), 7'(i + 64));
        expect_eq("R2", "stall when full", 32'(alloc_stall), 1);
        alloc_valid = 1'b1; alloc_areg = 5'd31; alloc_old_preg = 7'd127; alloc_new_preg = 7'd127;
        @(negedge clk);
        alloc_valid = 1'b0;
        expect_eq("R2", "tag held when full", 32'(alloc_tag), 32'(exp_tail));
        for (int i = DEPTH - 1; i >= 0; i--) begin
            do_cpl((first + i) % DEPTH, 2'd0, 0, 0);
            if (i != 0) expect_eq("R3", "no commit before head", 32'(commit_valid), 0);
        end
        for (int i = 0; i < DEPTH; i++) begin
            expect_commit("R4", 5'(i), 7'(i + 64), 7'(i + 8));
            @(negedge clk);
        end
        expect_quiet("R2");
        expect_eq("R2", "stall released", 32'(alloc_stall), 0);
    endtask

    task automatic t_mispredict;
        int t;
        t = exp_tail;
        do_alloc(5'd1, 7'd1, 7'd40);
        do_alloc(5'd2, 7'd2, 7'd41);
        do_alloc(5'd3, 7'd3, 7'd42);
        do_cpl((t + 1) % DEPTH, 2'd3, 32'h0, 5'd7);
        expect_eq("R9", "younger flag no flush", 32'(flush_valid), 0);
        do_cpl(t, 2'd1, 32'h100, 5'd0);
        expect_commit("R5", 5'd1, 7'd40, 7'd1);
        expect_eq("R5", "flush_valid", 32'(flush_valid), 1);
        expect_eq("R5", "flush_pc", flush_pc, 32'h100);
        expect_eq("R5", "flush_exception", 32'(flush_exception), 0);
        expect_eq("R8", "stall in flush cycle", 32'(alloc_stall), 1);
        @(negedge clk);
        expect_squash(7'd41);
        @(negedge clk);
        expect_squash(7'd42);
        @(negedge clk);
        expect_quiet("R8");
        expect_eq("R8", "stall released", 32'(alloc_stall), 0);
    endtask

    task automatic t_order_violation;
        int t;
        t = exp_tail;
        do_alloc(5'd4, 7'd4, 7'd50);
        do_alloc(5'd5, 7'd5, 7'd51);
        do_cpl(t, 2'd2, 32'h200, 5'd0);
        expect_eq("R6", "no commit", 32'(commit_valid), 0);
        expect_eq("R6", "flush_valid", 32'(flush_valid), 1);
        expect_eq("R6", "flush_pc", flush_pc, 32'h200);
        expect_eq("R6", "flush_exception", 32'(flush_exception), 0);
        @(negedge clk);
        expect_squash(7'd50);
        @(negedge clk);
        expect_squash(7'd51);
        @(negedge clk);
        expect_quiet("R6");
    endtask

    task automatic t_exception;
        int t;
        t = exp_tail;
        do_alloc(5'd6, 7'd6, 7'd60);
        do_alloc(5'd7, 7'd7, 7'd61);
        do_cpl(t, 2'd3, 32'h0, 5'd5);
        expect_eq("R7", "no commit", 32'(commit_valid), 0);
        expect_eq("R7", "flush_valid", 32'(flush_valid), 1);
        expect_eq("R7", "flush_pc", flush_pc, HANDLER);
        expect_eq("R7", "flush_exception", 32'(flush_exception), 1);
        expect_eq("R7", "flush_cause", 32'(flush_cause), 5);
        // Stimulus during the squash window must have no effect
        alloc_valid = 1'b1; alloc_areg = 5'd30; alloc_old_preg = 7'd99; alloc_new_preg = 7'd98;
        cpl_valid = 1'b1; cpl_tag = 3'((t + 1) % DEPTH); cpl_kind = 2'd0;
        @(negedge clk);
        expect_squash(7'd60);
        @(negedge clk);
        alloc_valid = 1'b0; cpl_valid = 1'b0;
        expect_squash(7'd61);
        @(negedge clk);
        expect_quiet("R8");
        expect_eq("R8", "tag continues", 32'(alloc_tag), 32'(exp_tail));
        t = exp_tail;
        do_alloc(5'd9, 7'd19, 7'd29);
        do_cpl(t, 2'd0, 0, 0);
        expect_commit("R8", 5'd9, 7'd29, 7'd19);
        @(negedge clk);
        expect_quiet("R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_out_of_order();
        t_fill_wrap();
        t_mispredict();
        t_order_violation();
        t_exception();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule